// File: doc/BRIEF.md
# Byte-Register Access Slave on a Two-Wire Serial Bus

This block lets an external two-wire (I2C) bus master write and read a bank of byte-wide registers that sit inside the chip. Both bus lines are sampled by the fast system clock. The block finds the bus conditions and the SCL edges in that clock domain. It drives SDA as an open-drain line through an output enable, so a low is driven and a high is released.

The slave responds only to its fixed 7-bit device address. Every access starts with a write of one byte that loads a register pointer.

- In a write, one data byte follows the pointer. The block hands that byte to the register bank with a single-cycle write strobe.
- In a read, the master sends a repeated START and the device address with the read bit set. The block issues a single-cycle read strobe and shifts one byte out of the bank, most significant bit first. It then releases the bus until the next START or STOP.

The parallel side is a plain port: address, write data, write strobe, read data and read strobe. The register address port always carries the current pointer.

Top module: `i2c_reg_slave`

## Requirements
- R1: While rst_ni is low, and right after it rises, sda_oe_o is 0, reg_we_o and reg_re_o are 0, and reg_addr_o is 0x00. The pointer is cleared only by this reset.
- R2: A high-to-low SDA transition while SCL is high starts address reception. This holds from any state, including a repeated START in the middle of a transaction and a START while the slave is ignoring the bus.
- R3: The first byte after a START carries the device address in bits 7..1 and the direction in bit 0 (0 = master writes, 1 = master reads). If bits 7..1 equal 0x74, the slave pulls SDA low during the ninth clock. Otherwise it never drives SDA and leaves reg_we_o low until the next START or STOP.
- R4: In a write, the second byte is loaded into the pointer and acknowledged. The third byte is acknowledged and presented on reg_wdata_o with a one-cycle reg_we_o pulse, while reg_addr_o holds the pointer.
- R5: After address+R is acknowledged, reg_re_o pulses for one cycle with reg_addr_o equal to the pointer. reg_rdata_i is taken at the SCL falling edge that ends the acknowledge clock. It is sent MSB first, with SDA driven low for each 0 bit and released for each 1 bit.
- R6: After the eighth bit of a read byte, SDA is released and stays released through the master's acknowledge clock and until the next START or STOP.
- R7: A low-to-high SDA transition while SCL is high returns the slave to idle and releases SDA, at any point in a transaction.
- R8: sda_oe_o changes only after a synchronized SCL falling edge or a bus condition, and never while SCL is high.
- R9: The pointer is kept across STOP. A read issued without a preceding pointer write returns the register at the last loaded pointer.
- R10: Any byte after the data byte of a write is not acknowledged and produces no write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 10x the SCL rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe_o | output | 1 | Pull SDA low when 1, release when 0 |
| reg_addr_o | output | 8 | Register pointer to the bank |
| reg_wdata_o | output | 8 | Write data to the bank |
| reg_we_o | output | 1 | One-cycle write strobe |
| reg_rdata_i | input | 8 | Read data from the bank at reg_addr_o |
| reg_re_o | output | 1 | One-cycle read strobe |

## Verification
The sharpest coincidence is a bus condition arriving in a cycle where the byte engine would otherwise act on an SCL edge. Examples are a STOP right after an acknowledge, a repeated START while the slave is ignoring a foreign address, and a repeated START straight after the pointer byte. The bench provokes each of these and judges the outcome at the ports. It checks that the acknowledge bit appears or does not, that SDA is released, and that the next transaction's write or read strobes reach a scoreboard queue with the right address and data. A second coincidence is the read strobe and the pointer update. The monitor compares reg_addr_o on every reg_re_o pulse against the pointer the driver last sent, including after a reset that clears it.

// File: rtl/i2c_reg_pkg.sv
package i2c_reg_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned BIT_CW   = $clog2(BYTE_W + 1);

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_PTR,
    ST_PTR_ACK,
    ST_WDAT,
    ST_WDAT_ACK,
    ST_RDAT,
    ST_SKIP
  } slv_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) chain_q[0] <= RST_VAL;
          else         chain_q[0] <= d_i;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) chain_q[s] <= RST_VAL;
          else         chain_q[s] <= chain_q[s-1];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int unsigned NLINES = 2;

  logic [NLINES-1:0] raw_w, sync_w, prev_q;

  assign raw_w = {sda_i, scl_i};

  generate
    for (genvar l = 0; l < NLINES; l++) begin : g_line
      i2c_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (raw_w[l]),
        .q_o   (sync_w[l])
      );
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= '1;
    else         prev_q <= sync_w;

  logic scl_s, sda_s, scl_p, sda_p;
  assign scl_s = sync_w[0];
  assign sda_s = sync_w[1];
  assign scl_p = prev_q[0];
  assign sda_p = prev_q[1];

  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_p;
  assign scl_fall_o = ~scl_s & scl_p;
  // conditions need SCL high on both samples
  assign start_o    = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_o     = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
  import i2c_reg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h74
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic [BYTE_W-1:0] reg_addr_o,
  output logic [BYTE_W-1:0] reg_wdata_o,
  output logic              reg_we_o,
  output logic              reg_re_o,
  input  logic [BYTE_W-1:0] reg_rdata_i,
  output logic              idle_o
);
  localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(BYTE_W);

  slv_state_e        st_q;
  logic [BIT_CW-1:0] cnt_q;
  logic [BYTE_W-1:0] sh_q, tx_q, ptr_q, wdat_q;
  logic              oe_q, rd_q, we_q, re_q;
  logic              byte_done;

  assign byte_done = scl_fall_i && (cnt_q == LAST_BIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      sh_q   <= '0;
      tx_q   <= '0;
      ptr_q  <= '0;
      wdat_q <= '0;
      oe_q   <= 1'b0;
      rd_q   <= 1'b0;
      we_q   <= 1'b0;
      re_q   <= 1'b0;
    end else begin
      we_q <= 1'b0;
      re_q <= 1'b0;
      if (stop_i) begin
        st_q <= ST_IDLE;
        oe_q <= 1'b0;
      end else if (start_i) begin
        st_q  <= ST_DEV;
        oe_q  <= 1'b0;
        cnt_q <= '0;
      end else begin
        unique case (st_q)
          ST_DEV, ST_PTR, ST_WDAT: begin
            if (scl_rise_i) begin
              sh_q  <= {sh_q[BYTE_W-2:0], sda_i};
              cnt_q <= cnt_q + 1'b1;
            end else if (byte_done) begin
              cnt_q <= '0;
              if (st_q == ST_DEV) begin
                if (sh_q[BYTE_W-1:1] == DEV_ADDR) begin
                  oe_q <= 1'b1;
                  rd_q <= sh_q[0];
                  re_q <= sh_q[0];
                  st_q <= ST_DEV_ACK;
                end else begin
                  st_q <= ST_SKIP;
                end
              end else if (st_q == ST_PTR) begin
                ptr_q <= sh_q;
                oe_q  <= 1'b1;
                st_q  <= ST_PTR_ACK;
              end else begin
                wdat_q <= sh_q;
                we_q   <= 1'b1;
                oe_q   <= 1'b1;
                st_q   <= ST_WDAT_ACK;
              end
            end
          end
          ST_DEV_ACK: begin
            if (scl_fall_i) begin
              cnt_q <= '0;
              if (rd_q) begin
                tx_q <= reg_rdata_i;
                oe_q <= ~reg_rdata_i[BYTE_W-1];
                st_q <= ST_RDAT;
              end else begin
                oe_q <= 1'b0;
                st_q <= ST_PTR;
              end
            end
          end
          ST_PTR_ACK: begin
            if (scl_fall_i) begin
              oe_q <= 1'b0;
              st_q <= ST_WDAT;
            end
          end
          ST_WDAT_ACK: begin
            if (scl_fall_i) begin
              oe_q <= 1'b0;
              st_q <= ST_SKIP;
            end
          end
          ST_RDAT: begin
            if (scl_rise_i) begin
              cnt_q <= cnt_q + 1'b1;
            end else if (byte_done) begin
              oe_q  <= 1'b0;
              cnt_q <= '0;
              st_q  <= ST_SKIP;
            end else if (scl_fall_i) begin
              tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
              oe_q <= ~tx_q[BYTE_W-2];
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o    = oe_q;
  assign reg_addr_o  = ptr_q;
  assign reg_wdata_o = wdat_q;
  assign reg_we_o    = we_q;
  assign reg_re_o    = re_q;
  assign idle_o      = (st_q == ST_IDLE);
endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave #(
  parameter logic [6:0]  DEV_ADDR    = 7'h74,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  output logic [7:0] reg_addr_o,
  output logic [7:0] reg_wdata_o,
  output logic       reg_we_o,
  input  logic [7:0] reg_rdata_i,
  output logic       reg_re_o
);
  logic sda_w, scl_rise_w, scl_fall_w, start_w, stop_w, idle_w;

  i2c_bus_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_o     (sda_w),
    .scl_rise_o(scl_rise_w),
    .scl_fall_o(scl_fall_w),
    .start_o   (start_w),
    .stop_o    (stop_w)
  );

  i2c_slave_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_rise_i (scl_rise_w),
    .scl_fall_i (scl_fall_w),
    .start_i    (start_w),
    .stop_i     (stop_w),
    .sda_i      (sda_w),
    .sda_oe_o   (sda_oe_o),
    .reg_addr_o (reg_addr_o),
    .reg_wdata_o(reg_wdata_o),
    .reg_we_o   (reg_we_o),
    .reg_re_o   (reg_re_o),
    .reg_rdata_i(reg_rdata_i),
    .idle_o     (idle_w)
  );
endmodule

// File: rtl/i2c_reg_slave_chk.sv
module i2c_reg_slave_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sda_oe_o,
  input logic reg_we_o,
  input logic reg_re_o,
  input logic start_w,
  input logic stop_w,
  input logic scl_fall_w,
  input logic idle_w
);
  assert_stop_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_w |=> !sda_oe_o);

  assert_start_release_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_w |=> !sda_oe_o);

  assert_idle_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_w |-> !sda_oe_o);

  assert_oe_on_fall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_w || stop_w || scl_fall_w) |=> $stable(sda_oe_o));

  assert_we_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);

  assert_re_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_re_o |=> !reg_re_o);

  assert_strobe_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_o && reg_re_o));
endmodule

bind i2c_reg_slave i2c_reg_slave_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sda_oe_o  (sda_oe_o),
  .reg_we_o  (reg_we_o),
  .reg_re_o  (reg_re_o),
  .start_w   (start_w),
  .stop_w    (stop_w),
  .scl_fall_w(scl_fall_w),
  .idle_w    (idle_w)
);

// File: tb/i2c_reg_slave_tb_top.sv
module i2c_reg_slave_tb_top;
  localparam int Q = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       m_scl = 1'b1;
  logic       m_sda = 1'b1;
  logic       sda_oe;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic       reg_we, reg_re;
  logic       sda_bus;

  int n_chk = 0;
  int n_err = 0;

  logic [15:0] wr_q[$];
  logic [7:0]  rd_q[$];
  logic [7:0]  bank [256];
  logic [7:0]  shadow [256];

  always #4 clk = ~clk;

  assign sda_bus   = m_sda & ~sda_oe;
  assign reg_rdata = bank[reg_addr];

  always_ff @(posedge clk)
    if (reg_we) bank[reg_addr] <= reg_wdata;

  i2c_reg_slave dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .scl_i      (m_scl),
    .sda_i      (sda_bus),
    .sda_oe_o   (sda_oe),
    .reg_addr_o (reg_addr),
    .reg_wdata_o(reg_wdata),
    .reg_we_o   (reg_we),
    .reg_re_o   (reg_re),
    .reg_rdata_i(reg_rdata)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && reg_we) begin
      if (wr_q.size() == 0) chk(1'b0, "R4/R10 unexpected write", {reg_addr, reg_wdata}, 0);
      else begin
        logic [15:0] e;
        e = wr_q.pop_front();
        chk({reg_addr, reg_wdata} == e, "R4 write strobe", {reg_addr, reg_wdata}, e);
      end
    end
    if (rst_n && reg_re) begin
      if (rd_q.size() == 0) chk(1'b0, "R5 unexpected read", reg_addr, 0);
      else begin
        logic [7:0] e;
        e = rd_q.pop_front();
        chk(reg_addr == e, "R5 read strobe address", reg_addr, e);
      end
    end
  end

  task automatic bus_start();
    m_scl = 1'b0; wq();
    m_sda = 1'b1; wq();
    m_scl = 1'b1; wq();
    m_sda = 1'b0; wq();
    m_scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    m_scl = 1'b0;
    m_sda = 1'b0; wq();
    m_scl = 1'b1; wq();
    m_sda = 1'b1; wq();
  endtask

  task automatic put_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wq();
      m_scl = 1'b1; wq(); wq();
      m_scl = 1'b0;
    end
    m_sda = 1'b1; wq();
    m_scl = 1'b1; wq();
    ack = (sda_bus == 1'b0);
    wq();
    m_scl = 1'b0; wq();
  endtask

  task automatic get_byte(input bit nack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      logic oe_a;
      wq();
      m_scl = 1'b1; wq();
      oe_a = sda_oe;
      b[i] = sda_bus;
      repeat (Q - 1) @(negedge clk);
      chk(sda_oe == oe_a, "R8 SDA stable while SCL high", sda_oe, oe_a);
      @(negedge clk);
      m_scl = 1'b0;
    end
    m_sda = nack; wq();
    m_scl = 1'b1; wq();
    chk(sda_oe == 1'b0, "R6 released during master ack clock", sda_oe, 0);
    wq();
    m_scl = 1'b0; wq();
    m_sda = 1'b1;
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d, input string tag);
    bit k;
    bus_start();
    put_byte(8'hE8, k); chk(k, {tag, " addr+W ack"}, k, 1);
    put_byte(a, k);     chk(k, {tag, " pointer ack"}, k, 1);
    wr_q.push_back({a, d});
    shadow[a] = d;
    put_byte(d, k);     chk(k, {tag, " data ack"}, k, 1);
    bus_stop();
  endtask

  task automatic do_read(input logic [7:0] a, input string tag);
    bit k;
    logic [7:0] v;
    bus_start();
    put_byte(8'hE8, k); chk(k, {tag, " addr+W ack"}, k, 1);
    put_byte(a, k);     chk(k, {tag, " pointer ack"}, k, 1);
    bus_start();
    rd_q.push_back(a);
    put_byte(8'hE9, k); chk(k, {tag, " addr+R ack"}, k, 1);
    get_byte(1'b1, v);  chk(v == shadow[a], {tag, " read data"}, v, shadow[a]);
    bus_stop();
    repeat (4) @(negedge clk);
    chk(sda_oe == 1'b0, "R6 released after read", sda_oe, 0);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    bit k;
    logic [7:0] v;
    repeat (5) @(negedge clk);
    chk(sda_oe == 0 && reg_we == 0 && reg_re == 0, "R1 reset outputs", {sda_oe, reg_we, reg_re}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(reg_addr == 8'h00, "R1 pointer after reset", reg_addr, 0);

    do_write(8'h00, 8'h5A, "R4 write reg0");
    do_write(8'h05, 8'hA5, "R4 write");
    do_write(8'h10, 8'h3C, "R4 write");
    do_read(8'h05, "R5 read");
    do_read(8'h10, "R5 read");

    // foreign address, then repeated START while ignoring
    bus_start();
    put_byte(8'hEA, k); chk(!k, "R3 foreign address no ack", k, 0);
    put_byte(8'h20, k); chk(!k, "R3 ignored byte no ack", k, 0);
    chk(sda_oe == 1'b0, "R3 SDA untouched", sda_oe, 0);
    bus_start();
    put_byte(8'hE8, k); chk(k, "R2 start from ignore ack", k, 1);
    put_byte(8'h30, k); chk(k, "R2 pointer ack", k, 1);
    wr_q.push_back({8'h30, 8'h77}); shadow[8'h30] = 8'h77;
    put_byte(8'h77, k); chk(k, "R2 data ack", k, 1);
    bus_stop();

    // extra byte after data
    bus_start();
    put_byte(8'hE8, k); chk(k, "R10 addr ack", k, 1);
    put_byte(8'h40, k); chk(k, "R10 pointer ack", k, 1);
    wr_q.push_back({8'h40, 8'h11}); shadow[8'h40] = 8'h11;
    put_byte(8'h11, k); chk(k, "R10 data ack", k, 1);
    put_byte(8'h22, k); chk(!k, "R10 extra byte no ack", k, 0);
    bus_stop();
    do_read(8'h40, "R10 readback");

    // pointer retained across STOP
    bus_start();
    rd_q.push_back(8'h40);
    put_byte(8'hE9, k); chk(k, "R9 addr+R ack", k, 1);
    get_byte(1'b1, v);  chk(v == 8'h11, "R9 read at kept pointer", v, 8'h11);
    bus_stop();

    // STOP right after address acknowledge
    bus_start();
    put_byte(8'hE8, k); chk(k, "R7 addr ack", k, 1);
    bus_stop();
    repeat (6) @(negedge clk);
    chk(sda_oe == 1'b0, "R7 released after STOP", sda_oe, 0);
    do_write(8'h7F, 8'h81, "R7 write after abort");
    do_read(8'h7F, "R7 read after abort");

    // reset clears pointer
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(reg_addr == 8'h00, "R1 pointer cleared", reg_addr, 0);
    bus_start();
    rd_q.push_back(8'h00);
    put_byte(8'hE9, k); chk(k, "R1 addr+R ack", k, 1);
    get_byte(1'b1, v);  chk(v == 8'h5A, "R1 read at cleared pointer", v, 8'h5A);
    bus_stop();

    repeat (20) @(negedge clk);
    chk(wr_q.size() == 0, "R4 all writes seen", wr_q.size(), 0);
    chk(rd_q.size() == 0, "R5 all reads seen", rd_q.size(), 0);
    summary();
    $finish;
  end
endmodule